// File: doc/BRIEF.md
# Port I/O Privilege Gate

This block rules on whether an I/O-sensitive instruction may run under the current privilege state. Each request gives an instruction kind, the current privilege level, the I/O privilege level taken from the flags, a port number and an access width, plus the task record's limit and the offset of its per-port permission bitmap. Port reads and writes, and the instructions that set or clear the interrupt flag, are allowed or raise a general protection fault (vector 13). A flags-pop request never faults. For a flags-pop request the block reports which of the two guarded flag fields the pop may update.

When the privilege level is at least as privileged as the I/O level (a numerically lower or equal value), the answer comes back on the request cycle. A less privileged port access is decided from the task's bitmap, which holds one bit per byte-wide port. The block fetches one or two bitmap bytes through a simple read port. The verdict comes one cycle after the last byte arrives. While a lookup runs, `busy` is high and new requests are not taken. The requester holds its request until it sees `busy` low.

Top module: `io_perm_gate`

## Requirements
- R1: When `req_cpl` <= `req_iopl`, a request of kind 0 (port I/O) or kind 1 (interrupt-flag set/clear, kind 3 behaves the same) is allowed on the request cycle, with no bitmap read.
- R2: When `req_cpl` > `req_iopl`, a kind 1 request faults on the request cycle: `rsp_fault`=1, `rsp_allow`=0, `rsp_vector`=13.
- R3: When `req_cpl` > `req_iopl`, a port I/O request for port p tests bit p[2:0] of the bitmap byte at offset `bm_base` + (p >> 3). A bit value of 0 allows the access and 1 faults it with vector 13.
- R4: If `bm_base` >= `tss_limit`, there is no bitmap. A port request that needs the bitmap faults on the request cycle and no byte is read.
- R5: A bitmap byte whose offset is greater than `tss_limit` counts as all ones (denied) and is never read. If the first byte is past the limit, the fault comes on the request cycle. If only the second byte is past the limit, the fault comes after the first byte has been read.
- R6: `req_size` 0, 1 and 2 (or 3) select 1, 2 and 4 bytes. The access covers ports p to p+n-1 and is allowed only if all their bits are 0. When those bits fall in two bitmap bytes, the lower offset is fetched first, then the next.
- R7: Kind 2 (flags pop) never faults and answers on the request cycle with `rsp_allow`=1. `rsp_wr_iopl`=1 only when `req_cpl`=0, and `rsp_wr_if`=1 only when `req_cpl` <= `req_iopl`. Both are 0 for other kinds.
- R8: A bitmap verdict appears on `rsp_valid` exactly one cycle after the `mem_rd_valid` of the last byte. `busy` stays high from the accepting edge until that response, and requests offered while busy are ignored.
- R9: After reset, `busy`, `rsp_valid` and `mem_rd_en` are 0.
- R10: Each bitmap byte is requested by a single one-cycle pulse of `mem_rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; taken when `busy` is low |
| req_kind | input | 2 | 0 port I/O, 1 interrupt-flag set/clear, 2 flags pop, 3 as 1 |
| req_cpl | input | 2 | Current privilege level |
| req_iopl | input | 2 | I/O privilege level from the flags |
| req_port | input | 16 | Port number |
| req_size | input | 2 | Access width code (1, 2, 4 bytes) |
| bm_base | input | 16 | Bitmap offset within the task record |
| tss_limit | input | 32 | Last valid byte offset of the task record |
| mem_rd_en | output | 1 | Bitmap byte read strobe |
| mem_rd_addr | output | 32 | Byte offset being read |
| mem_rd_valid | input | 1 | Read data returned |
| mem_rd_data | input | 8 | Returned bitmap byte |
| busy | output | 1 | Lookup in progress |
| rsp_valid | output | 1 | Verdict present |
| rsp_allow | output | 1 | Instruction may proceed |
| rsp_fault | output | 1 | General protection fault |
| rsp_vector | output | 8 | 13 when faulting, else 0 |
| rsp_wr_iopl | output | 1 | Flags pop may update the I/O level field |
| rsp_wr_if | output | 1 | Flags pop may update the interrupt flag |

## Verification
Requests are driven with privilege pairs on both sides of the comparison, so the fast path can be told apart from the bitmap path. Port numbers and widths are chosen to hit a denied bit at the first, middle and last covered position, and to either stay inside one bitmap byte or straddle two. This separates mask placement errors from byte-address errors. Limits are placed so that no bitmap exists, the first byte is out of range, or only the second byte is out of range. For each case the bench checks both the verdict and the number of cycles and reads it took. A request held during a lookup shows whether busy requests are ignored.

// File: rtl/io_perm_pkg.sv
package io_perm_pkg;

  typedef enum logic [1:0] {
    KIND_PORT  = 2'd0,
    KIND_IFLAG = 2'd1,
    KIND_POPF  = 2'd2,
    KIND_RSVD  = 2'd3
  } io_kind_e;

  localparam logic [7:0] GP_VECTOR = 8'd13;

  // width code -> byte count
  function automatic logic [3:0] size_to_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd1;
      2'd1:    return 4'd2;
      default: return 4'd4;
    endcase
  endfunction

  // bits covered by an access, across two adjacent bitmap bytes
  function automatic logic [15:0] span_mask(input logic [2:0] bit_off,
                                            input logic [3:0] nbytes);
    logic [15:0] m;
    m = (16'd1 << nbytes) - 16'd1;
    return m << bit_off;
  endfunction

endpackage

// File: rtl/io_perm_decide.sv
module io_perm_decide
  import io_perm_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic [1:0]        kind,
  input  logic [1:0]        cpl,
  input  logic [1:0]        iopl,
  input  logic [PORT_W-1:0] port,
  input  logic [1:0]        size,
  input  logic [OFF_W-1:0]  base,
  input  logic [ADDR_W-1:0] limit,
  output logic              need_walk,
  output logic              fast_allow,
  output logic              wr_iopl,
  output logic              wr_if,
  output logic [ADDR_W-1:0] first_addr,
  output logic [ADDR_W-1:0] second_addr,
  output logic              spans,
  output logic              second_ok,
  output logic [15:0]       mask
);
  localparam int IDX_W = PORT_W - 3;

  logic privileged, is_popf, is_port, bm_present, first_ok;

  assign privileged  = (cpl <= iopl);
  assign is_popf     = (kind == KIND_POPF);
  assign is_port     = (kind == KIND_PORT);
  assign bm_present  = (ADDR_W'(base) < limit);
  assign first_addr  = ADDR_W'(base) + ADDR_W'(port[PORT_W-1:3]);
  assign second_addr = first_addr + ADDR_W'(1);
  assign first_ok    = (first_addr <= limit);
  assign second_ok   = (second_addr <= limit);
  assign mask        = span_mask(port[2:0], size_to_bytes(size));
  assign spans       = |mask[15:8];

  assign need_walk  = is_port && !privileged && bm_present && first_ok;
  assign fast_allow = is_popf || privileged;
  assign wr_iopl    = is_popf && (cpl == 2'd0);
  assign wr_if      = is_popf && privileged;

  localparam int UNUSED_IDX = IDX_W;
endmodule

// File: rtl/io_perm_walker.sv
module io_perm_walker #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [ADDR_W-1:0] second_addr,
  input  logic              spans,
  input  logic              second_ok,
  input  logic [15:0]       mask,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [7:0]        mem_rd_data,
  output logic              busy,
  output logic              done,
  output logic              done_deny,
  output logic              last_byte_evt
);
  typedef enum logic [2:0] {
    W_IDLE, W_ISSUE0, W_WAIT0, W_ISSUE1, W_WAIT1, W_RESP
  } wstate_e;

  wstate_e           state_q;
  logic [ADDR_W-1:0] addr_q, addr1_q;
  logic [7:0]        mask_lo_q, mask_hi_q;
  logic              two_q, ok2_q, deny_q;
  logic              hit_lo, hit_hi;

  assign hit_lo = |(mem_rd_data & mask_lo_q);
  assign hit_hi = |(mem_rd_data & mask_hi_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= W_IDLE;
      addr_q    <= '0;
      addr1_q   <= '0;
      mask_lo_q <= '0;
      mask_hi_q <= '0;
      two_q     <= 1'b0;
      ok2_q     <= 1'b0;
      deny_q    <= 1'b0;
    end else begin
      case (state_q)
        W_IDLE: if (start) begin
          addr_q    <= first_addr;
          addr1_q   <= second_addr;
          mask_lo_q <= mask[7:0];
          mask_hi_q <= mask[15:8];
          two_q     <= spans;
          ok2_q     <= second_ok;
          deny_q    <= 1'b0;
          state_q   <= W_ISSUE0;
        end
        W_ISSUE0: state_q <= W_WAIT0;
        W_WAIT0: if (mem_rd_valid) begin
          if (two_q && ok2_q) begin
            deny_q  <= hit_lo;
            addr_q  <= addr1_q;
            state_q <= W_ISSUE1;
          end else begin
            deny_q  <= hit_lo || two_q;
            state_q <= W_RESP;
          end
        end
        W_ISSUE1: state_q <= W_WAIT1;
        W_WAIT1: if (mem_rd_valid) begin
          deny_q  <= deny_q || hit_hi;
          state_q <= W_RESP;
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end

  assign mem_rd_en     = (state_q == W_ISSUE0) || (state_q == W_ISSUE1);
  assign mem_rd_addr   = addr_q;
  assign busy          = (state_q != W_IDLE);
  assign done          = (state_q == W_RESP);
  assign done_deny     = deny_q;
  assign last_byte_evt = mem_rd_valid &&
                         ((state_q == W_WAIT1) ||
                          ((state_q == W_WAIT0) && !(two_q && ok2_q)));

  // R10: every read strobe lasts a single cycle
  assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  // R8: verdict one cycle after the final byte returns
  assert_resp_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte_evt |=> done);

  // R8: busy holds through the response cycle
  assert_busy_until_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
endmodule

// File: rtl/io_perm_gate.sv
module io_perm_gate
  import io_perm_pkg::*;
#(
  parameter int PORT_W = 16,
  parameter int OFF_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_cpl,
  input  logic [1:0]        req_iopl,
  input  logic [PORT_W-1:0] req_port,
  input  logic [1:0]        req_size,
  input  logic [OFF_W-1:0]  bm_base,
  input  logic [ADDR_W-1:0] tss_limit,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [7:0]        mem_rd_data,
  output logic              busy,
  output logic              rsp_valid,
  output logic              rsp_allow,
  output logic              rsp_fault,
  output logic [7:0]        rsp_vector,
  output logic              rsp_wr_iopl,
  output logic              rsp_wr_if
);
  logic              need_walk, fast_allow, d_wr_iopl, d_wr_if;
  logic [ADDR_W-1:0] first_addr, second_addr;
  logic              spans, second_ok;
  logic [15:0]       mask;
  logic              accept, fast_rsp, start;
  logic              done, done_deny, last_byte_evt;

  io_perm_decide #(.PORT_W(PORT_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_decide (
    .kind(req_kind), .cpl(req_cpl), .iopl(req_iopl), .port(req_port),
    .size(req_size), .base(bm_base), .limit(tss_limit),
    .need_walk(need_walk), .fast_allow(fast_allow),
    .wr_iopl(d_wr_iopl), .wr_if(d_wr_if),
    .first_addr(first_addr), .second_addr(second_addr),
    .spans(spans), .second_ok(second_ok), .mask(mask)
  );

  assign accept   = req_valid && !busy;
  assign start    = accept && need_walk;
  assign fast_rsp = accept && !need_walk;

  io_perm_walker #(.ADDR_W(ADDR_W)) u_walker (
    .clk(clk), .rst_n(rst_n), .start(start),
    .first_addr(first_addr), .second_addr(second_addr),
    .spans(spans), .second_ok(second_ok), .mask(mask),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .busy(busy), .done(done), .done_deny(done_deny),
    .last_byte_evt(last_byte_evt)
  );

  assign rsp_valid   = fast_rsp || done;
  assign rsp_allow   = done ? !done_deny : (fast_rsp && fast_allow);
  assign rsp_fault   = rsp_valid && !rsp_allow;
  assign rsp_vector  = rsp_fault ? GP_VECTOR : 8'd0;
  assign rsp_wr_iopl = fast_rsp && d_wr_iopl;
  assign rsp_wr_if   = fast_rsp && d_wr_if;

  // R1: privileged port I/O and flag instructions pass at once
  assert_priv_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_kind != KIND_POPF && req_cpl <= req_iopl)
      |-> (rsp_valid && rsp_allow));

  // R2: unprivileged flag set/clear faults at once
  assert_iflag_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_kind == KIND_IFLAG && req_cpl > req_iopl)
      |-> (rsp_valid && rsp_fault && rsp_vector == 8'd13));

  // R4: absent bitmap faults without any read
  assert_no_bitmap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_kind == KIND_PORT && req_cpl > req_iopl &&
     ADDR_W'(bm_base) >= tss_limit) |=> !mem_rd_en);

  // R7: flags pop never faults
  assert_popf_no_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && req_kind == KIND_POPF) |-> (rsp_valid && !rsp_fault));

  // R8: a busy block does not answer a fresh request on the spot
  assert_busy_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |-> !rsp_valid);

  // R9: quiet outputs right after reset
  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |=> (!busy && !mem_rd_en));
endmodule

// File: tb/io_perm_gate_bench.sv
`timescale 1ns/1ps
module io_perm_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0, req_cpl = '0, req_iopl = '0, req_size = '0;
  logic [15:0] req_port = '0;
  logic [15:0] bm_base = 16'd8;
  logic [31:0] tss_limit = 32'd23;
  logic        mem_rd_en, mem_rd_valid;
  logic [31:0] mem_rd_addr;
  logic [7:0]  mem_rd_data;
  logic        busy, rsp_valid, rsp_allow, rsp_fault, rsp_wr_iopl, rsp_wr_if;
  logic [7:0]  rsp_vector;

  always #2 clk = ~clk;

  io_perm_gate u_io_perm_gate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_cpl(req_cpl), .req_iopl(req_iopl), .req_port(req_port),
    .req_size(req_size), .bm_base(bm_base), .tss_limit(tss_limit),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_allow(rsp_allow),
    .rsp_fault(rsp_fault), .rsp_vector(rsp_vector),
    .rsp_wr_iopl(rsp_wr_iopl), .rsp_wr_if(rsp_wr_if)
  );

  // bitmap memory, one cycle read latency
  logic [7:0] bm [64];
  int rd_count = 0;
  always_ff @(posedge clk) begin
    mem_rd_valid <= mem_rd_en;
    mem_rd_data  <= bm[mem_rd_addr[5:0]];
    if (mem_rd_en) rd_count <= rd_count + 1;
  end

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // expected verdict: {reads[1:0], lat[3:0], allow}
  function automatic logic [6:0] model(input logic [1:0] k, input logic [1:0] cpl,
      input logic [1:0] iopl, input logic [1:0] sz, input int p,
      input int base, input int lim);
    int n, first, last, off;
    logic deny;
    n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    if (k == 2 || cpl <= iopl) return {2'd0, 4'd0, 1'b1};
    if (k != 0) return {2'd0, 4'd0, 1'b0};
    if (base >= lim) return {2'd0, 4'd0, 1'b0};
    first = base + p / 8;
    last  = base + (p + n - 1) / 8;
    if (first > lim) return {2'd0, 4'd0, 1'b0};
    deny = 1'b0;
    for (int q = p; q < p + n; q++) begin
      off = base + q / 8;
      if (off > lim || bm[off][q % 8]) deny = 1'b1;
    end
    if (last != first && last <= lim) return {2'd2, 4'd5, !deny};
    return {2'd1, 4'd3, !deny};
  endfunction

  task automatic run_req(input logic [1:0] k, input logic [1:0] cpl,
      input logic [1:0] iopl, input logic [1:0] sz, input logic [15:0] p,
      input string tag);
    logic [6:0] e;
    int lat, rd0;
    logic a, f, wi, wf;
    logic [7:0] v;
    e = model(k, cpl, iopl, sz, int'(p), int'(bm_base), int'(tss_limit));
    @(negedge clk);
    rd0 = rd_count;
    req_kind = k; req_cpl = cpl; req_iopl = iopl; req_size = sz; req_port = p;
    req_valid = 1'b1;
    #1;
    lat = -1;
    if (rsp_valid) begin
      lat = 0; a = rsp_allow; f = rsp_fault; v = rsp_vector;
      wi = rsp_wr_iopl; wf = rsp_wr_if;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    if (lat < 0) begin
      int n;
      n = 1;
      while (!rsp_valid && n < 20) begin
        @(posedge clk); @(negedge clk); #1; n++;
      end
      lat = n; a = rsp_allow; f = rsp_fault; v = rsp_vector;
      wi = rsp_wr_iopl; wf = rsp_wr_if;
    end
    @(posedge clk); @(negedge clk);
    chk(tag, "allow", a, e[0]);
    chk(tag, "fault", f, !e[0]);
    chk(tag, "vector", v, e[0] ? 0 : 13);
    chk("R8", "latency", lat, e[4:1]);
    chk("R10", "reads", rd_count - rd0, e[6:5]);
    if (k == 2) begin
      chk("R7", "wr_iopl", wi, cpl == 0);
      chk("R7", "wr_if", wf, cpl <= iopl);
    end else begin
      chk("R7", "wr_iopl_other", wi, 0);
      chk("R7", "wr_if_other", wf, 0);
    end
  endtask

  // {kind, cpl, iopl, size, port}
  localparam logic [23:0] VEC [16] = '{
    {2'd0, 2'd0, 2'd0, 2'd0, 16'h0040},
    {2'd1, 2'd3, 2'd3, 2'd0, 16'h0000},
    {2'd1, 2'd3, 2'd0, 2'd0, 16'h0000},
    {2'd0, 2'd3, 2'd0, 2'd0, 16'd5},
    {2'd0, 2'd3, 2'd0, 2'd0, 16'd9},
    {2'd0, 2'd3, 2'd0, 2'd2, 16'd12},
    {2'd0, 2'd3, 2'd0, 2'd1, 16'd10},
    {2'd0, 2'd3, 2'd0, 2'd1, 16'd22},
    {2'd0, 2'd3, 2'd0, 2'd1, 16'd21},
    {2'd0, 2'd3, 2'd0, 2'd2, 16'd30},
    {2'd0, 2'd3, 2'd1, 2'd2, 16'd14},
    {2'd0, 2'd2, 2'd1, 2'd2, 16'd22},
    {2'd2, 2'd0, 2'd0, 2'd0, 16'd0},
    {2'd2, 2'd3, 2'd2, 2'd0, 16'd0},
    {2'd2, 2'd1, 2'd2, 2'd0, 16'd0},
    {2'd3, 2'd2, 2'd1, 2'd0, 16'd0}
  };

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog run did not complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) bm[i] = 8'hFF;
    for (int i = 8; i < 23; i++) bm[i] = 8'h00;
    bm[9]  = 8'h0F;
    bm[10] = 8'h80;
    bm[23] = 8'hFF;

    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R9", "busy", busy, 0);
    chk("R9", "rsp_valid", rsp_valid, 0);
    chk("R9", "mem_rd_en", mem_rd_en, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 16; i++) begin
      logic [1:0] k, c, o;
      string tag;
      k = VEC[i][23:22]; c = VEC[i][21:20]; o = VEC[i][19:18];
      if (k == 2) tag = "R7";
      else if (c <= o) tag = "R1";
      else if (k != 0) tag = "R2";
      else if (VEC[i][17:16] != 0) tag = "R6";
      else tag = "R3";
      run_req(k, c, o, VEC[i][17:16], VEC[i][15:0], tag);
    end

    // R4: bitmap absent
    bm_base = 16'd8; tss_limit = 32'd8;
    run_req(2'd0, 2'd3, 2'd0, 2'd0, 16'd0, "R4");
    // R5: first byte past the limit
    tss_limit = 32'd9;
    run_req(2'd0, 2'd3, 2'd0, 2'd0, 16'd70, "R5");
    // R5: second byte past the limit, first byte clear
    run_req(2'd0, 2'd3, 2'd0, 2'd1, 16'd15, "R5");
    tss_limit = 32'd23;

    // R8: request held during a lookup is ignored until done
    begin
      int n, seen, rd0;
      logic first_allow, first_wi;
      @(negedge clk);
      rd0 = rd_count;
      req_kind = 2'd0; req_cpl = 2'd3; req_iopl = 2'd0; req_size = 2'd0;
      req_port = 16'd9; req_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      req_kind = 2'd2; req_cpl = 2'd0; req_iopl = 2'd0;
      n = 1; seen = 0; first_allow = 1'b1; first_wi = 1'b1;
      #1;
      while (n < 10) begin
        if (rsp_valid && seen == 0) begin
          first_allow = rsp_allow; first_wi = rsp_wr_iopl; seen = n;
        end
        if (seen != 0) break;
        @(posedge clk); @(negedge clk); #1; n++;
      end
      chk("R8", "held_lat", seen, 3);
      chk("R8", "held_verdict", first_allow, 0);
      chk("R8", "held_wr_iopl", first_wi, 0);
      @(posedge clk); @(negedge clk); #1;
      chk("R8", "next_accept", rsp_valid && rsp_wr_iopl, 1);
      req_valid = 1'b0;
      chk("R10", "held_reads", rd_count - rd0, 1);
    end

    repeat (3) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule